// File: doc/BRIEF.md
# Synchronous Byte Shift Port

This block is a half-duplex synchronous serial port that moves one byte at a time over a data line whose output driver it enables, while driving the shift clock itself. Time is organised into machine cycles. A phase counter splits each machine cycle into six states, S1 to S6, and splits each state into two phases, P1 and P2. One data bit moves per machine cycle.

A write strobe loads a byte and starts a transmit. A receive runs when receive is enabled, the receive-done flag is clear and no transmit is in progress. Neither direction uses a bit counter to find its end. Each shift register carries a marker bit that travels as the register shifts, and the transfer ends when the marker reaches its final position. Completion raises a done flag for that direction, and a finished receive also updates the received-byte register. A done flag stays set until a clear strobe removes it.

Top module: `sync_shift_port`

## Requirements
- R1: A phase counter steps through 12 phases, S1P1 (0) to S6P2 (11), and advances once every STEP_DIV clocks. A machine cycle is therefore 12*STEP_DIV clocks.
- R2: After reset, and whenever no transfer is running, `sclk` is high and `sd_oe` is low. After reset both done flags are 0 and `rx_byte` is 0.
- R3: A transmit drives the byte on `sd_out` least significant bit first, one bit per machine cycle, with `sd_oe` high for exactly 8 machine cycles. Each bit changes at the start of S1. `sclk` is low during S3 to S5 and high otherwise, so `sclk` falls 4 phases after `sd_oe` rises.
- R4: A write is taken at the S6P2 that follows the strobe. `sd_oe` rises at the start of the second machine cycle after that write cycle. `tx_done` rises on the same clock that `sd_oe` falls, at the start of the tenth machine cycle after the write cycle. This puts `tx_done` more than 9 and at most 10 machine cycles after the strobe.
- R5: A write strobe is ignored while a transmit is pending or running. The byte on the line and the number of bits sent do not change, and no second transmit follows.
- R6: A receive starts only when `rx_en` is 1, `rx_done` is 0 and no transmit is pending or running. Otherwise `sclk` stays high.
- R7: During a receive, `sd_in` is sampled at S5P2 of every machine cycle. The first bit received is stored in `rx_byte[0]` and the eighth in `rx_byte[7]`.
- R8: `rx_done` rises and `rx_byte` updates at the start of the tenth machine cycle after the cycle in which `rx_done` was cleared, which is 8 machine cycles minus 4 phases after the first falling edge of `sclk`. While `rx_done` stays 1, no new receive starts.
- R9: `clr_tx_done` and `clr_rx_done` each clear their own flag on the next clock.
- R10: Transmit and receive are never active at the same time. A write that arrives during a receive waits until the receive has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_buf | input | 1 | Transmit write strobe |
| wr_data | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| sd_in | input | 1 | Data line input |
| sd_out | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sclk | output | 1 | Shift clock |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| rx_byte | output | 8 | Last received byte |

## Verification
The assertions check the following on every cycle:
- the phase counter stays in range and advances in order;
- transmit and receive never overlap;
- the lines are idle whenever no transfer runs;
- `sclk` only ever falls at S3P1;
- each done flag rises at S1P1 on the same clock its active state ends.

Some properties cannot be seen from a single cycle. Only the bench scenarios can show them:
- that bytes arrive least significant bit first;
- the tenth-cycle spacing from a write or a flag clear;
- that ignored writes leave the transfer intact;
- that a transmit waits for a receive in progress.

The bench shows these by looping the port through a model of a peripheral shift register.

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int STEP_DIV = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_buf,
  input  logic [DW-1:0] wr_data,
  input  logic          rx_en,
  input  logic          clr_tx_done,
  input  logic          clr_rx_done,
  input  logic          sd_in,
  output logic          sd_out,
  output logic          sd_oe,
  output logic          sclk,
  output logic          tx_done,
  output logic          rx_done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [3:0] PH_S3P1 = 4'd4;
  localparam logic [3:0] PH_S5P2 = 4'd9;
  localparam logic [3:0] PH_S6P2 = 4'd11;

  typedef enum logic [1:0] {T_IDLE, T_PEND, T_WAIT, T_RUN} tx_st_t;
  typedef enum logic [1:0] {R_IDLE, R_ARM, R_RUN} rx_st_t;

  logic [CW-1:0] div;
  logic [3:0]    ph;
  logic          step, at_s6p2, at_s5p2;
  tx_st_t        tx_st;
  rx_st_t        rx_st;
  logic [DW:0]   tx_sr;
  logic [DW-1:0] rx_sr, rx_next, rx_rev;
  logic          smp;
  logic          tx_run, rx_run, busy, sclk_low;

  assign step    = (div == CW'(STEP_DIV - 1));
  assign at_s6p2 = step && (ph == PH_S6P2);
  assign at_s5p2 = step && (ph == PH_S5P2);
  assign tx_run  = (tx_st == T_RUN);
  assign rx_run  = (rx_st == R_RUN);
  assign busy    = tx_run || rx_run;
  assign sclk_low = (ph >= PH_S3P1) && (ph <= PH_S5P2);
  assign sclk    = !(busy && sclk_low);
  assign sd_oe   = tx_run;
  assign sd_out  = tx_sr[0];
  assign rx_next = {rx_sr[DW-2:0], smp};

  always_comb
    for (int i = 0; i < DW; i++) rx_rev[i] = rx_next[DW-1-i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div <= '0;
      ph  <= '0;
    end else if (step) begin
      div <= '0;
      ph  <= (ph == PH_S6P2) ? 4'd0 : ph + 4'd1;
    end else begin
      div <= div + CW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_st   <= T_IDLE;
      tx_sr   <= '0;
      tx_done <= 1'b0;
    end else begin
      if (clr_tx_done) tx_done <= 1'b0;
      case (tx_st)
        T_IDLE: if (wr_buf) begin
          tx_sr <= {1'b1, wr_data};
          tx_st <= T_PEND;
        end
        T_PEND: if (at_s6p2 && rx_st == R_IDLE) tx_st <= T_WAIT;
        T_WAIT: if (at_s6p2) tx_st <= T_RUN;
        default: if (at_s6p2) begin
          tx_sr <= {1'b0, tx_sr[DW:1]};
          if (tx_sr[DW:1] == {{(DW-1){1'b0}}, 1'b1}) begin
            tx_st   <= T_IDLE;
            tx_done <= 1'b1;
          end
        end
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st   <= R_IDLE;
      rx_sr   <= '0;
      rx_byte <= '0;
      rx_done <= 1'b0;
      smp     <= 1'b0;
    end else begin
      if (clr_rx_done) rx_done <= 1'b0;
      if (at_s5p2) smp <= sd_in;
      case (rx_st)
        R_IDLE: if (at_s6p2 && rx_en && !rx_done && tx_st == T_IDLE && !wr_buf)
          rx_st <= R_ARM;
        R_ARM: if (at_s6p2) begin
          rx_sr <= {{(DW-1){1'b1}}, 1'b0};
          rx_st <= R_RUN;
        end
        default: if (at_s6p2) begin
          rx_sr <= rx_next;
          if (!rx_sr[DW-1]) begin
            rx_byte <= rx_rev;
            rx_done <= 1'b1;
            rx_st   <= R_IDLE;
          end
        end
      endcase
    end
endmodule

module sync_shift_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ph,
  input logic       tx_run,
  input logic       rx_run,
  input logic       sclk,
  input logic       sd_oe,
  input logic       tx_done,
  input logic       rx_done
);
  // R1
  ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n) ph < 4'd12);
  // R1
  ph_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != $past(ph)) |-> (ph == (($past(ph) == 4'd11) ? 4'd0 : $past(ph) + 4'd1)));
  // R10
  half_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n) !(tx_run && rx_run));
  // R2
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_run || rx_run) |-> (sclk && !sd_oe));
  // R3
  sclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk) |-> ph == 4'd4);
  // R4
  tx_done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (ph == 4'd0 && $fell(tx_run)));
  // R8
  rx_done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> (ph == 4'd0 && $fell(rx_run)));
endmodule

bind sync_shift_port sync_shift_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .tx_run(tx_run), .rx_run(rx_run),
  .sclk(sclk), .sd_oe(sd_oe), .tx_done(tx_done), .rx_done(rx_done)
);

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
  localparam int DIV = 2;
  localparam int L = 12 * DIV;
  localparam int CLK_NS = 8;

  logic clk = 0, rst_n = 0;
  logic wr_buf = 0, rx_en = 0, clr_tx_done = 0, clr_rx_done = 0, sd_in = 0;
  logic [7:0] wr_data = 0;
  logic sd_out, sd_oe, sclk, tx_done, rx_done;
  logic [7:0] rx_byte;

  sync_shift_port #(.STEP_DIV(DIV)) i_sync_shift_port (
    .clk(clk), .rst_n(rst_n), .wr_buf(wr_buf), .wr_data(wr_data), .rx_en(rx_en),
    .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done), .sd_in(sd_in),
    .sd_out(sd_out), .sd_oe(sd_oe), .sclk(sclk), .tx_done(tx_done),
    .rx_done(rx_done), .rx_byte(rx_byte));

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] cap = 0, periph_byte = 0;
  int pcnt = 0, ridx = 0, n_fall = 0;
  time t_oe = 0, t_txd = 0, t_rxd = 0, t_ff = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pop_cmp(input string req, input logic [7:0] got);
    if (exp_q.size() == 0) chk(0, req, got, -1);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(got == e, req, got, e);
    end
  endtask

  // peripheral model: captures on rising sclk, drives on falling sclk
  always @(posedge sclk) if (sd_oe) begin
    cap = {sd_out, cap[7:1]};
    pcnt++;
    if (pcnt == 8) pop_cmp("R3 tx byte lsb first", cap);
  end
  always @(negedge sclk) begin
    n_fall++;
    if (n_fall == 1) t_ff = $time;
    if (!sd_oe) begin
      sd_in = periph_byte[ridx];
      ridx++;
    end
  end
  always @(posedge sd_oe) t_oe = $time;
  always @(posedge tx_done) t_txd = $time;
  always @(posedge rx_done) begin
    t_rxd = $time;
    #1 pop_cmp("R7 rx byte order", rx_byte);
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_wr(input logic [7:0] d);
    @(negedge clk); wr_buf = 1; wr_data = d;
    @(negedge clk); wr_buf = 0;
  endtask

  task automatic wait_flag(input bit rx);
    for (int i = 0; i < 14 * L; i++) begin
      if (rx ? rx_done : tx_done) break;
      @(negedge clk);
    end
  endtask

  task automatic tx_send(input logic [7:0] d, input bit extra_wr);
    time t_wr;
    exp_q.push_back(d);
    pcnt = 0; n_fall = 0;
    @(negedge clk); wr_buf = 1; wr_data = d; t_wr = $time;
    @(negedge clk); wr_buf = 0;
    if (extra_wr) begin
      cycles(4 * L);
      strobe_wr(~d);
    end
    wait_flag(0);
    chk(tx_done, "R4 tx_done set", tx_done, 1);
    chk((t_txd - t_wr) / CLK_NS > 9 * L && (t_txd - t_wr) / CLK_NS <= 10 * L,
        "R4 write to done window", (t_txd - t_wr) / CLK_NS, 10 * L);
    chk((t_txd - t_oe) / CLK_NS == 8 * L, "R3 oe length", (t_txd - t_oe) / CLK_NS, 8 * L);
    chk((t_txd - t_ff) / CLK_NS == 8 * L - 4 * DIV, "R3 sclk phase", (t_txd - t_ff) / CLK_NS, 8 * L - 4 * DIV);
    cycles(3 * L);
    chk(pcnt == 8, "R5 bit count", pcnt, 8);
    chk(sclk && !sd_oe, "R2 idle after tx", {sclk, sd_oe}, 2);
    @(negedge clk); clr_tx_done = 1;
    @(negedge clk); clr_tx_done = 0;
    chk(!tx_done, "R9 tx clear", tx_done, 0);
  endtask

  initial begin
    #(200000 * CLK_NS);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    time t_clr;
    cycles(5);
    rst_n = 1;
    @(negedge clk);
    chk(sclk && !sd_oe, "R2 reset lines", {sclk, sd_oe}, 2);
    chk(!tx_done && !rx_done, "R2 reset flags", {tx_done, rx_done}, 0);
    chk(rx_byte == 0, "R2 reset rx_byte", rx_byte, 0);
    n_fall = 0;
    cycles(3 * L);
    chk(n_fall == 0, "R6 no rx when disabled", n_fall, 0);

    tx_send(8'hA5, 1);
    tx_send(8'h01, 0);
    tx_send(8'h80, 0);

    // receive, started by enable
    periph_byte = 8'hB4; ridx = 0; n_fall = 0;
    exp_q.push_back(8'hB4);
    @(negedge clk); rx_en = 1;
    wait_flag(1);
    chk(rx_done, "R8 rx_done set", rx_done, 1);
    chk((t_rxd - t_ff) / CLK_NS == 8 * L - 4 * DIV, "R8 rx timing", (t_rxd - t_ff) / CLK_NS, 8 * L - 4 * DIV);
    cycles(2);
    n_fall = 0;
    cycles(3 * L);
    chk(n_fall == 0, "R8 no restart while done", n_fall, 0);

    // receive, started by flag clear
    periph_byte = 8'h6E; ridx = 0; n_fall = 0;
    exp_q.push_back(8'h6E);
    @(negedge clk); clr_rx_done = 1; t_clr = $time;
    @(negedge clk); clr_rx_done = 0;
    chk(!rx_done, "R9 rx clear", rx_done, 0);
    wait_flag(1);
    chk((t_rxd - t_clr) / CLK_NS > 9 * L && (t_rxd - t_clr) / CLK_NS <= 10 * L,
        "R8 clear to done window", (t_rxd - t_clr) / CLK_NS, 10 * L);

    // write during a receive waits
    periph_byte = 8'h0F; ridx = 0; n_fall = 0; pcnt = 0;
    exp_q.push_back(8'h0F);
    exp_q.push_back(8'h5A);
    @(negedge clk); clr_rx_done = 1;
    @(negedge clk); clr_rx_done = 0;
    cycles(4 * L);
    strobe_wr(8'h5A);
    wait_flag(1);
    wait_flag(0);
    chk(tx_done, "R10 tx after rx", tx_done, 1);
    chk(t_oe > t_rxd, "R10 tx waits for rx", t_oe / CLK_NS, t_rxd / CLK_NS);
    cycles(2 * L);
    chk(pcnt == 8, "R10 tx bits", pcnt, 8);
    @(negedge clk); clr_tx_done = 1;
    @(negedge clk); clr_tx_done = 0;

    // disabled receiver ignores flag clear
    rx_en = 0;
    @(negedge clk); clr_rx_done = 1;
    @(negedge clk); clr_rx_done = 0;
    n_fall = 0;
    cycles(3 * L);
    chk(n_fall == 0, "R6 no rx with enable low", n_fall, 0);
    chk(!rx_done && rx_byte == 8'h0F, "R6 rx state kept", rx_byte, 8'h0F);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule